// File: doc/BRIEF.md
# Address Table Command Engine

This block owns a small forwarding table of MAC address entries and carries out table commands issued by a host through a 16-bit register window. The host first fills in a database number, an entry data word (state, trunk flag, port vector) and a 48-bit MAC address. It then writes the operation register with the busy bit set and an opcode. The engine runs the command against its entry array in a single cycle, clears busy, and leaves any result in the same data and address registers.

There are four kinds of command. A load writes, overwrites or purges one entry. A get-next walks the table in ascending MAC order. A flush or move works on many entries at once, either across all databases or within one, and either on every entry or only on non-static ones.

The 4-bit state field does more than one job. In a load, zero purges the entry and any other value is a live entry. In a flush/move command, zero asks for a flush and 0xF asks for a move. Live states 1 to 7 are dynamic: a periodic aging tick counts them down, and the entry is freed when it reaches zero. State 0xE is static. The aging interval is the 8-bit age-time field multiplied by a fixed cycle coefficient, and a field value of zero stops aging.

Top module: `addr_table_engine`

## Requirements
- R1: Register addresses are 0 (wide database number), 1 (control), 2 (operation), 3 (data), and 4, 5 and 6 (MAC words). Writing the operation register with bit 15 set starts the command in bits 14:12. Bit 15 then reads 1 for exactly one cycle and 0 afterwards. Host writes to any register while bit 15 is set are ignored.
- R2: With the default 64 databases, the database number is operation bits 9:8 (upper two bits) followed by bits 3:0 (lower four bits). Entries in databases 5 and 37, which share their lower four bits, stay distinct.
- R3: In the data register, bits 3:0 hold the state, bits 11:4 hold the port vector (8 ports) and bit 15 holds the trunk flag. MAC word 4 holds address bytes 0 (high) and 1, word 5 holds bytes 2 and 3, and word 6 holds bytes 4 and 5. Byte 0 is the most significant byte for ordering.
- R4: Opcode 5 (load) with a nonzero state writes the entry for the given MAC and database. If that entry already exists, it is overwritten and no duplicate is made.
- R5: Opcode 5 with state zero purges the matching entry.
- R6: Opcode 6 (get-next) returns the valid entry of the selected database with the lowest MAC above the address registers. It writes that entry's state, port vector, trunk flag and MAC into the registers.
- R7: When no such entry exists, get-next returns MAC all-ones with a data word of zero. A start address of all-ones wraps to the lowest entry.
- R8: Opcodes 1 (every entry, all databases) and 2 (non-static only, all databases) act on every database. With data state 0 they free the selected entries. A static entry (state 0xE) survives opcode 2.
- R9: Opcodes 3 (every entry, one database) and 4 (non-static only, one database) act only on the selected database.
- R10: A flush/move command with data state 0xF is a move. Port vector bits 2:0 hold the source port and bits 5:3 hold the destination port. Each selected entry that contains the source port has that bit cleared and the destination bit set.
- R11: A move whose destination field is all-ones (7) only clears the source port. An entry whose port vector becomes empty is freed.
- R12: When the age-time field (control bits 11:4) is nonzero, a tick occurs every age-time × coefficient cycles. Each tick decrements every state in the range 1 to 7, and an entry reaching 0 is freed. States 0xE and 8 to 0xD are unchanged.
- R13: An age-time field of zero stops aging, so entry states stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register read data, combinational from reg_addr |

## Verification
A write to the operation register lands on the first rising edge and sets busy. The command executes on the next edge, which also clears busy and loads any get-next result. The bench therefore reads busy at the falling edge right after the write, and reads the registers one falling edge later. During that single busy cycle the bench drives a conflicting host write, then reads the register back to confirm the write was dropped. Aging latency depends on a free-running prescaler, so the bench does not expect an exact cycle there. It runs aging for windows that are known to be shorter or longer than the relevant number of ticks, and the per-tick decrement is checked exactly by the in-RTL properties.

// File: rtl/ate_pkg.sv
package ate_pkg;

  typedef enum logic [2:0] {
    CMD_NOP          = 3'd0,
    CMD_FM_ALL_ALLDB = 3'd1,
    CMD_FM_NS_ALLDB  = 3'd2,
    CMD_FM_ALL_ONEDB = 3'd3,
    CMD_FM_NS_ONEDB  = 3'd4,
    CMD_LOAD         = 3'd5,
    CMD_NEXT         = 3'd6
  } cmd_e;

  localparam logic [3:0] ST_EMPTY  = 4'h0;
  localparam logic [3:0] ST_STATIC = 4'hE;
  localparam logic [3:0] ST_MOVE   = 4'hF;

  localparam logic [2:0] A_DBX  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_OP   = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_MAC0 = 3'd4;
  localparam logic [2:0] A_MAC1 = 3'd5;
  localparam logic [2:0] A_MAC2 = 3'd6;

  // Gather the database number from wherever the table size places it.
  function automatic logic [11:0] db_assemble(input int num_db,
                                              input logic [15:0] opw,
                                              input logic [15:0] ctrlw,
                                              input logic [11:0] dbx);
    logic [11:0] d;
    if (num_db > 256) begin
      d = dbx;
    end else begin
      d = {8'h00, opw[3:0]};
      if (num_db > 64)      d[7:4] = ctrlw[15:12];
      else if (num_db > 16) d[5:4] = opw[9:8];
    end
    return d;
  endfunction

  function automatic logic is_dynamic(input logic [3:0] s);
    return (s != ST_EMPTY) && (s <= 4'd7);
  endfunction

endpackage

// File: rtl/ate_ager.sv
module ate_ager #(
  parameter int AGE_COEFF = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] age_time,
  input  logic       age_ack,
  output logic       age_req
);
  localparam int PW = (AGE_COEFF > 1) ? $clog2(AGE_COEFF) : 1;

  logic [PW-1:0] pre_q;
  logic [7:0]    steps_q;
  logic          pend_q;
  logic          step_evt;

  assign step_evt = (pre_q == PW'(AGE_COEFF - 1));
  assign age_req  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      steps_q <= '0;
      pend_q  <= 1'b0;
    end else if (age_time == 8'd0) begin
      pre_q   <= '0;
      steps_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (age_ack) pend_q <= 1'b0;
      if (step_evt) begin
        pre_q <= '0;
        if (steps_q + 8'd1 >= age_time) begin
          steps_q <= '0;
          pend_q  <= 1'b1;
        end else begin
          steps_q <= steps_q + 8'd1;
        end
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  AST_AGE_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (age_time == 8'd0) |=> !age_req); // R13
  AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    age_ack |-> age_req); // R12

endmodule

// File: rtl/ate_regs.sv
module ate_regs
  import ate_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int NUM_DB = 64,
  parameter int DBW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              busy,
  output cmd_e              cmd,
  output logic [DBW-1:0]    db,
  output logic [3:0]        st,
  output logic              trunk,
  output logic [NPORTS-1:0] pv,
  output logic [47:0]       mac,
  output logic [7:0]        age_time,
  input  logic              done,
  input  logic              res_we,
  input  logic [3:0]        res_state,
  input  logic              res_trunk,
  input  logic [NPORTS-1:0] res_pv,
  input  logic [47:0]       res_mac
);
  logic [11:0] dbx_q;
  logic [15:0] ctrl_q, op_q, data_q;
  logic [47:0] mac_q;
  logic [15:0] res_word;

  assign busy     = op_q[15];
  assign cmd      = cmd_e'(op_q[14:12]);
  assign db       = DBW'(db_assemble(NUM_DB, op_q, ctrl_q, dbx_q));
  assign st       = data_q[3:0];
  assign pv       = data_q[4 +: NPORTS];
  assign trunk    = data_q[15];
  assign mac      = mac_q;
  assign age_time = ctrl_q[11:4];

  always_comb begin
    res_word              = '0;
    res_word[3:0]         = res_state;
    res_word[4 +: NPORTS] = res_pv;
    res_word[15]          = res_trunk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbx_q  <= '0;
      ctrl_q <= '0;
      op_q   <= '0;
      data_q <= '0;
      mac_q  <= '0;
    end else if (busy) begin
      if (done) op_q[15] <= 1'b0;
      if (res_we) begin
        data_q <= res_word;
        mac_q  <= res_mac;
      end
    end else if (wr_en) begin
      case (reg_addr)
        A_DBX:  dbx_q          <= wr_data[11:0];
        A_CTRL: ctrl_q         <= wr_data;
        A_OP:   op_q           <= wr_data;
        A_DATA: data_q         <= wr_data;
        A_MAC0: mac_q[47:32]   <= wr_data;
        A_MAC1: mac_q[31:16]   <= wr_data;
        A_MAC2: mac_q[15:0]    <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_DBX:   rd_data = {4'h0, dbx_q};
      A_CTRL:  rd_data = ctrl_q;
      A_OP:    rd_data = op_q;
      A_DATA:  rd_data = data_q;
      A_MAC0:  rd_data = mac_q[47:32];
      A_MAC1:  rd_data = mac_q[31:16];
      A_MAC2:  rd_data = mac_q[15:0];
      default: rd_data = 16'h0000;
    endcase
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R1
  AST_BUSY_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && reg_addr == A_MAC0 && cmd != CMD_NEXT) |=> $stable(mac_q[47:32])); // R1

endmodule

// File: rtl/ate_table.sv
module ate_table
  import ate_pkg::*;
#(
  parameter int NENT   = 8,
  parameter int NPORTS = 8,
  parameter int DBW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  cmd_e              cmd,
  input  logic [DBW-1:0]    db,
  input  logic [3:0]        st_in,
  input  logic              trunk_in,
  input  logic [NPORTS-1:0] pv_in,
  input  logic [47:0]       mac_in,
  input  logic              age_req,
  output logic              age_ack,
  output logic              done,
  output logic              res_we,
  output logic [3:0]        res_state,
  output logic              res_trunk,
  output logic [NPORTS-1:0] res_pv,
  output logic [47:0]       res_mac
);
  localparam int PIDW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1;

  logic [3:0]        e_st  [NENT];
  logic [DBW-1:0]    e_db  [NENT];
  logic [47:0]       e_mac [NENT];
  logic [NPORTS-1:0] e_pv  [NENT];
  logic              e_tr  [NENT];

  logic [NENT-1:0]   hit, freev, cand, sel, has_from;
  logic [NPORTS-1:0] moved [NENT];
  logic              any_hit, any_free, found, wrap, all_db, all_kind, dup;
  logic [IW-1:0]     hit_idx, free_idx, nxt_idx, wr_idx;
  logic [47:0]       best_mac;
  logic [PIDW-1:0]   mv_from, mv_to;

  assign mv_from = pv_in[PIDW-1:0];
  assign mv_to   = pv_in[2*PIDW-1:PIDW];

  // Port vector after moving one port: source bit cleared, destination set
  // unless the destination is the all-ones "remove" code.
  function automatic logic [NPORTS-1:0] move_vec(input logic [NPORTS-1:0] v,
                                                 input logic [PIDW-1:0] from,
                                                 input logic [PIDW-1:0] to);
    logic [NPORTS-1:0] r;
    r = v & ~(NPORTS'(1) << from);
    if (to != {PIDW{1'b1}}) r = r | (NPORTS'(1) << to);
    return r;
  endfunction

  always_comb begin
    all_db   = (cmd == CMD_FM_ALL_ALLDB) || (cmd == CMD_FM_NS_ALLDB);
    all_kind = (cmd == CMD_FM_ALL_ALLDB) || (cmd == CMD_FM_ALL_ONEDB);
    wrap     = &mac_in;
    any_hit  = 1'b0;
    any_free = 1'b0;
    found    = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    nxt_idx  = '0;
    best_mac = '1;
    dup      = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      hit[i]      = (e_st[i] != ST_EMPTY) && (e_db[i] == db) && (e_mac[i] == mac_in);
      freev[i]    = (e_st[i] == ST_EMPTY);
      cand[i]     = (e_st[i] != ST_EMPTY) && (e_db[i] == db) && (wrap || e_mac[i] > mac_in);
      sel[i]      = (e_st[i] != ST_EMPTY) && (all_db || e_db[i] == db) &&
                    (all_kind || e_st[i] != ST_STATIC);
      has_from[i] = |(e_pv[i] & (NPORTS'(1) << mv_from));
      moved[i]    = move_vec(e_pv[i], mv_from, mv_to);
      if (hit[i] && !any_hit) begin
        any_hit = 1'b1;
        hit_idx = IW'(i);
      end
      if (freev[i] && !any_free) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (cand[i] && (!found || e_mac[i] < best_mac)) begin
        found    = 1'b1;
        nxt_idx  = IW'(i);
        best_mac = e_mac[i];
      end
      for (int j = i + 1; j < NENT; j++) begin
        if (e_st[i] != ST_EMPTY && e_st[j] != ST_EMPTY &&
            e_db[i] == e_db[j] && e_mac[i] == e_mac[j]) dup = 1'b1;
      end
    end
    wr_idx = any_hit ? hit_idx : free_idx;
  end

  assign done      = go;
  assign res_we    = go && (cmd == CMD_NEXT);
  assign res_state = found ? e_st[nxt_idx] : ST_EMPTY;
  assign res_trunk = found ? e_tr[nxt_idx] : 1'b0;
  assign res_pv    = found ? e_pv[nxt_idx] : '0;
  assign res_mac   = found ? best_mac : '1;
  assign age_ack   = age_req && !go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        e_st[i]  <= ST_EMPTY;
        e_db[i]  <= '0;
        e_mac[i] <= '0;
        e_pv[i]  <= '0;
        e_tr[i]  <= 1'b0;
      end
    end else if (go) begin
      case (cmd)
        CMD_LOAD: begin
          if (st_in == ST_EMPTY) begin
            for (int i = 0; i < NENT; i++)
              if (hit[i]) e_st[i] <= ST_EMPTY;
          end else if (any_hit || any_free) begin
            e_st[wr_idx]  <= st_in;
            e_db[wr_idx]  <= db;
            e_mac[wr_idx] <= mac_in;
            e_pv[wr_idx]  <= pv_in;
            e_tr[wr_idx]  <= trunk_in;
          end
        end
        CMD_FM_ALL_ALLDB, CMD_FM_NS_ALLDB, CMD_FM_ALL_ONEDB, CMD_FM_NS_ONEDB: begin
          for (int i = 0; i < NENT; i++) begin
            if (sel[i]) begin
              if (st_in == ST_EMPTY) begin
                e_st[i] <= ST_EMPTY;
              end else if (st_in == ST_MOVE && has_from[i]) begin
                e_pv[i] <= moved[i];
                if (moved[i] == '0) e_st[i] <= ST_EMPTY;
              end
            end
          end
        end
        default: ;
      endcase
    end else if (age_req) begin
      for (int i = 0; i < NENT; i++)
        if (is_dynamic(e_st[i])) e_st[i] <= e_st[i] - 4'd1;
    end
  end

  AST_NO_DUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) !dup); // R4

  for (genvar g = 0; g < NENT; g++) begin : g_chk
    AST_STATIC_NO_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      (age_ack && e_st[g] == ST_STATIC) |=> (e_st[g] == ST_STATIC)); // R12
    AST_AGE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (age_ack && is_dynamic(e_st[g])) |=> (e_st[g] == $past(e_st[g]) - 4'd1)); // R12
  end

endmodule

// File: rtl/addr_table_engine.sv
module addr_table_engine
  import ate_pkg::*;
#(
  parameter int NENT      = 8,
  parameter int NPORTS    = 8,
  parameter int NUM_DB    = 64,
  parameter int AGE_COEFF = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  localparam int DBW = (NUM_DB > 1) ? $clog2(NUM_DB) : 1;

  logic              busy, trunk, done, res_we, res_trunk, age_req, age_ack;
  cmd_e              cmd;
  logic [DBW-1:0]    db;
  logic [3:0]        st, res_state;
  logic [NPORTS-1:0] pv, res_pv;
  logic [47:0]       mac, res_mac;
  logic [7:0]        age_time;

  ate_regs #(.NPORTS(NPORTS), .NUM_DB(NUM_DB), .DBW(DBW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .cmd(cmd), .db(db),
    .st(st), .trunk(trunk), .pv(pv), .mac(mac), .age_time(age_time),
    .done(done), .res_we(res_we), .res_state(res_state),
    .res_trunk(res_trunk), .res_pv(res_pv), .res_mac(res_mac)
  );

  ate_table #(.NENT(NENT), .NPORTS(NPORTS), .DBW(DBW)) u_table (
    .clk(clk), .rst_n(rst_n), .go(busy), .cmd(cmd), .db(db), .st_in(st),
    .trunk_in(trunk), .pv_in(pv), .mac_in(mac), .age_req(age_req),
    .age_ack(age_ack), .done(done), .res_we(res_we), .res_state(res_state),
    .res_trunk(res_trunk), .res_pv(res_pv), .res_mac(res_mac)
  );

  ate_ager #(.AGE_COEFF(AGE_COEFF)) u_ager (
    .clk(clk), .rst_n(rst_n), .age_time(age_time), .age_ack(age_ack),
    .age_req(age_req)
  );

endmodule

// File: tb/addr_table_engine_tb.sv
`timescale 1ns/1ps
module addr_table_engine_tb;

  localparam logic [2:0] OP_ALL_ALL = 3'd1, OP_NS_ALL = 3'd2, OP_ALL_ONE = 3'd3,
                         OP_NS_ONE = 3'd4, OP_LOAD = 3'd5, OP_NEXT = 3'd6;
  localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  addr_table_engine #(.NENT(8), .NPORTS(8), .NUM_DB(64), .AGE_COEFF(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [15:0] dword(input logic [3:0] s, input logic [7:0] p, input logic t);
    return (16'(t) << 15) + (16'(p) << 4) + 16'(s);
  endfunction

  function automatic logic [15:0] opword(input logic [2:0] c, input logic [5:0] d);
    return 16'h8000 + (16'(c) << 12) + (16'(d[5:4]) << 8) + 16'(d[3:0]);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd4, m[47:32]); wr(3'd5, m[31:16]); wr(3'd6, m[15:0]);
  endtask

  task automatic run(input logic [2:0] c, input logic [5:0] d);
    wr(3'd2, opword(c, d));
    @(negedge clk);
  endtask

  task automatic load(input logic [5:0] d, input logic [47:0] m, input logic [3:0] s,
                      input logic [7:0] p, input logic t);
    set_mac(m);
    wr(3'd3, dword(s, p, t));
    run(OP_LOAD, d);
  endtask

  task automatic fm(input logic [2:0] c, input logic [5:0] d, input logic [3:0] s, input logic [7:0] p);
    wr(3'd3, dword(s, p, 1'b0));
    run(c, d);
  endtask

  task automatic nxt(input logic [5:0] d, input logic [47:0] start,
                     output logic [15:0] dat, output logic [47:0] m);
    logic [15:0] w0, w1, w2;
    set_mac(start);
    run(OP_NEXT, d);
    rd(3'd3, dat);
    rd(3'd4, w0); rd(3'd5, w1); rd(3'd6, w2);
    m = {w0, w1, w2};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, w0, w1, w2;
    logic [47:0] m;
    logic [3:0]  st_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1)
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset register", 64'(d), 64'h0);
    end

    // populate: db 5 and db 37 share the lower database bits (R2)
    load(6'd5,  48'h10, 4'd7, 8'h03, 1'b0);
    load(6'd5,  48'hA0, 4'hE, 8'h04, 1'b0);
    load(6'd5,  48'h50, 4'd9, 8'h81, 1'b1);
    load(6'd37, 48'h0123_4567_89AB, 4'd3, 8'h02, 1'b0);

    // ascending walk (R4, R6)
    nxt(6'd5, 48'h0, d, m);
    check("R6 walk first mac", 64'(m), 64'h10);
    check("R4 walk first data", 64'(d), 64'(dword(4'd7, 8'h03, 1'b0)));
    nxt(6'd5, 48'h10, d, m);
    check("R6 walk second mac", 64'(m), 64'h50);
    check("R3 data field layout", 64'(d), 64'(dword(4'd9, 8'h81, 1'b1)));
    nxt(6'd5, 48'h50, d, m);
    check("R6 walk third mac", 64'(m), 64'hA0);
    nxt(6'd5, 48'hA0, d, m);
    check("R7 end marker mac", 64'(m), 64'(ONES));
    check("R7 end marker data", 64'(d), 64'h0);
    nxt(6'd5, ONES, d, m);
    check("R7 wrap to lowest", 64'(m), 64'h10);

    // MAC word layout and database separation (R3, R2)
    nxt(6'd37, 48'h0, d, m);
    rd(3'd4, w0); rd(3'd5, w1); rd(3'd6, w2);
    check("R3 mac word 4", 64'(w0), 64'h0123);
    check("R3 mac word 5", 64'(w1), 64'h4567);
    check("R3 mac word 6", 64'(w2), 64'h89AB);
    check("R2 db37 state", 64'(d[3:0]), 64'd3);
    nxt(6'd21, 48'h0, d, m);
    check("R2 db21 empty", 64'(m), 64'(ONES));

    // overwrite and purge (R4, R5)
    load(6'd5, 48'h10, 4'd5, 8'h10, 1'b1);
    nxt(6'd5, 48'h0, d, m);
    check("R4 overwrite data", 64'(d), 64'(dword(4'd5, 8'h10, 1'b1)));
    nxt(6'd5, 48'h10, d, m);
    check("R4 no duplicate", 64'(m), 64'h50);
    load(6'd5, 48'h50, 4'd0, 8'hFF, 1'b0);
    nxt(6'd5, 48'h10, d, m);
    check("R5 purge", 64'(m), 64'hA0);

    // host write during busy is ignored (R1)
    set_mac(48'h1111_2222_3333);
    wr(3'd3, dword(4'hE, 8'h01, 1'b0));
    wr(3'd2, opword(OP_LOAD, 6'd9));
    rd(3'd2, d);
    check("R1 busy set", 64'(d[15]), 64'd1);
    wr_en = 1'b1; reg_addr = 3'd4; wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd2, d);
    check("R1 busy cleared", 64'(d[15]), 64'd0);
    rd(3'd4, d);
    check("R1 write ignored while busy", 64'(d), 64'h1111);

    // move (R10): entry 0x10 has port 4 only
    fm(OP_NS_ONE, 6'd5, 4'hF, 8'((6 << 3) | 4));
    nxt(6'd5, 48'h0, d, m);
    check("R10 move vector", 64'(d), 64'(dword(4'd5, 8'h40, 1'b1)));
    nxt(6'd5, 48'h10, d, m);
    check("R10 static untouched", 64'(d), 64'(dword(4'hE, 8'h04, 1'b0)));

    // remove (R11)
    load(6'd5, 48'h60, 4'd9, 8'h0C, 1'b0);
    fm(OP_ALL_ALL, 6'd0, 4'hF, 8'((7 << 3) | 6));
    nxt(6'd5, 48'h0, d, m);
    check("R11 emptied entry freed", 64'(m), 64'h60);
    fm(OP_ALL_ONE, 6'd5, 4'hF, 8'((7 << 3) | 2));
    nxt(6'd5, 48'h0, d, m);
    check("R11 partial remove mac", 64'(m), 64'h60);
    check("R11 partial remove vector", 64'(d), 64'(dword(4'd9, 8'h08, 1'b0)));
    nxt(6'd5, 48'h60, d, m);
    check("R11 static removed by all-kind", 64'(m), 64'(ONES));
    nxt(6'd37, 48'h0, d, m);
    check("R9 other db untouched by remove", 64'(d), 64'(dword(4'd3, 8'h02, 1'b0)));

    // one-database flushes (R9, R8)
    load(6'd5,  48'hA0, 4'hE, 8'h04, 1'b0);
    load(6'd5,  48'h10, 4'd2, 8'h01, 1'b0);
    load(6'd37, 48'h20, 4'hE, 8'h01, 1'b0);
    fm(OP_NS_ONE, 6'd5, 4'd0, 8'h00);
    nxt(6'd5, 48'h0, d, m);
    check("R8 static survives non-static flush", 64'(m), 64'hA0);
    nxt(6'd37, 48'h0, d, m);
    check("R9 one-db flush scope", 64'(m), 64'h20);
    fm(OP_ALL_ONE, 6'd37, 4'd0, 8'h00);
    nxt(6'd37, 48'h0, d, m);
    check("R9 all-kind flush one db", 64'(m), 64'(ONES));
    nxt(6'd5, 48'h0, d, m);
    check("R9 db5 kept", 64'(m), 64'hA0);

    // all-database flushes (R8)
    load(6'd37, 48'h20, 4'hE, 8'h01, 1'b0);
    load(6'd5,  48'h30, 4'd1, 8'h01, 1'b0);
    fm(OP_NS_ALL, 6'd0, 4'd0, 8'h00);
    nxt(6'd5, 48'h0, d, m);
    check("R8 non-static all-db flush", 64'(m), 64'hA0);
    nxt(6'd37, 48'h0, d, m);
    check("R8 static kept in other db", 64'(m), 64'h20);
    fm(OP_ALL_ALL, 6'd0, 4'd0, 8'h00);
    nxt(6'd5, 48'h0, d, m);
    check("R8 full flush db5", 64'(m), 64'(ONES));
    nxt(6'd37, 48'h0, d, m);
    check("R8 full flush db37", 64'(m), 64'(ONES));

    // aging (R12, R13)
    load(6'd5, 48'h11, 4'd7, 8'h01, 1'b0);
    load(6'd5, 48'h22, 4'hE, 8'h02, 1'b0);
    load(6'd5, 48'h33, 4'd9, 8'h04, 1'b0);
    wr(3'd1, 16'h0010);
    repeat (14) @(negedge clk);
    wr(3'd1, 16'h0000);
    nxt(6'd5, 48'h10, d, m);
    st_a = d[3:0];
    check("R12 aged entry present", 64'(m), 64'h11);
    check("R12 partial decrement", 64'(st_a > 4'd0 && st_a < 4'd7), 64'd1);
    repeat (50) @(negedge clk);
    nxt(6'd5, 48'h10, d, m);
    check("R13 frozen when disabled", 64'(d[3:0]), 64'(st_a));
    wr(3'd1, 16'h0020);
    repeat (100) @(negedge clk);
    wr(3'd1, 16'h0000);
    nxt(6'd5, 48'h0, d, m);
    check("R12 dynamic freed", 64'(m), 64'h22);
    check("R12 static kept", 64'(d[3:0]), 64'hE);
    nxt(6'd5, 48'h22, d, m);
    check("R12 state 9 kept", 64'(d[3:0]), 64'd9);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule